// File: doc/BRIEF.md
# NaN Detect and Quieting Unit

This block inspects one binary64 operand per transfer. It reports whether the operand is a NaN and whether that NaN is signaling. On request it turns a signaling NaN into a quiet NaN and raises an invalid-operation flag. A run-time mode input selects between two opposite quiet-bit conventions:

- **2008 convention:** a set top fraction bit marks a quiet NaN.
- **Legacy convention:** a set top fraction bit marks a signaling NaN.

In the legacy convention, clearing the top fraction bit can leave a fraction of zero, which would read as an infinity. In that case the block sets the next fraction bit so that the result is still a NaN.

Operands enter on a valid/ready stream and results leave on another. Between them sit the combinational classify and quiet logic and then one register stage.

- An input transfer happens on a rising edge where `in_valid` and `in_ready` are both high.
- An output transfer happens on a rising edge where `out_valid` and `out_ready` are both high.
- `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. A full stream therefore runs at one item per cycle.
- While the consumer holds `out_ready` low, the registered result and its flags stay frozen.

The mode and request inputs are sampled together with the operand.

Top module: `nanq_unit`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `out_is_nan` is 1 exactly when the operand's exponent field (bits 62:52) is all ones and its fraction (bits 51:0) is nonzero. Infinity is not a NaN.
- R3: `out_is_snan` is 1 for a NaN when `mode_2008` XOR fraction bit 51 equals 1. With `mode_2008`=1 a clear bit 51 means signaling. With `mode_2008`=0 a set bit 51 means signaling.
- R4: With `mode_2008`=1, quieting a signaling NaN sets fraction bit 51 and keeps every other bit, sign included.
- R5: With `mode_2008`=0, quieting a signaling NaN clears fraction bit 51 and keeps every other bit, sign included, when the remaining fraction is nonzero.
- R6: With `mode_2008`=0, if clearing bit 51 leaves a fraction of zero, fraction bit 50 is set, so the result is still a NaN.
- R7: `out_invalid` is 1 exactly when `in_quiet_req` was 1 and the operand was a signaling NaN.
- R8: When `in_quiet_req` is 0 or the operand is not a signaling NaN, `out_data` equals the operand and `out_invalid` is 0.
- R9: A result appears on the output one cycle after its input transfer. While `out_valid` is high and `out_ready` is low, the output is held stable. `in_ready` equals (not `out_valid`) or `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block accepts input this cycle |
| in_data | input | 64 | binary64 operand |
| in_quiet_req | input | 1 | Quiet a signaling NaN and flag invalid |
| mode_2008 | input | 1 | 1: set bit 51 means quiet; 0: legacy convention |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts result |
| out_data | output | 64 | Result value |
| out_is_nan | output | 1 | Operand was a NaN |
| out_is_snan | output | 1 | Operand was a signaling NaN |
| out_invalid | output | 1 | Invalid-operation flag raised |

## Verification
The hardest case to reach is the legacy repair. It needs a signaling NaN whose only set fraction bit is bit 51, with quieting requested and `mode_2008` low. The stimulus sends that operand directly, with and without a sign, so that the repair path to bit 50 is taken. It also sends a near twin with one low payload bit set, which must not be repaired. A pseudo-random `out_ready` pattern then stalls results in the output stage, so the hold and back-pressure rules are exercised on the same items.

// File: rtl/nanq_pkg.sv
package nanq_pkg;
  localparam int unsigned DEF_EXP_W  = 11;
  localparam int unsigned DEF_FRAC_W = 52;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic invalid;
  } nanq_flags_t;
endpackage

// File: rtl/nanq_classify.sv
module nanq_classify #(
  parameter int unsigned EXP_W  = nanq_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W = nanq_pkg::DEF_FRAC_W,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] operand,
  input  logic         mode_2008,
  output logic         is_nan,
  output logic         is_snan
);
  localparam int unsigned QB = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              frac_nz;

  assign exp_f   = operand[W-2 -: EXP_W];
  assign frac_f  = operand[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    is_nan  = exp_max && frac_nz;
    is_snan = is_nan && (mode_2008 ^ frac_f[QB]);
  end
endmodule

// File: rtl/nanq_quieter.sv
module nanq_quieter #(
  parameter int unsigned EXP_W  = nanq_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W = nanq_pkg::DEF_FRAC_W,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] operand,
  input  logic         mode_2008,
  input  logic         quiet_req,
  input  logic         is_snan,
  output logic [W-1:0] result,
  output logic         invalid
);
  localparam int unsigned QB = FRAC_W - 1;
  localparam int unsigned RB = FRAC_W - 2;

  logic [FRAC_W-1:0] frac_in;
  logic [FRAC_W-1:0] frac_set;
  logic [FRAC_W-1:0] frac_clr;
  logic [FRAC_W-1:0] frac_legacy;
  logic [FRAC_W-1:0] frac_out;
  logic              do_quiet;

  assign frac_in = operand[FRAC_W-1:0];

  always_comb begin
    frac_set     = frac_in;
    frac_set[QB] = 1'b1;
    frac_clr     = frac_in;
    frac_clr[QB] = 1'b0;
    frac_legacy  = frac_clr;
    if (frac_clr == '0) begin
      frac_legacy[RB] = 1'b1;
    end
  end

  assign do_quiet = quiet_req && is_snan;

  always_comb begin
    frac_out = frac_in;
    if (do_quiet) begin
      frac_out = mode_2008 ? frac_set : frac_legacy;
    end
  end

  assign result  = {operand[W-1:FRAC_W], frac_out};
  assign invalid = do_quiet;
endmodule

// File: rtl/nanq_stage.sv
module nanq_stage #(
  parameter int unsigned DW = 67
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_payload,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_payload
);
  logic          full_q;
  logic [DW-1:0] data_q;
  logic          load;

  assign s_ready = !full_q || m_ready;
  assign load    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (s_ready) begin
      full_q <= s_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      data_q <= s_payload;
    end
  end

  assign m_valid   = full_q;
  assign m_payload = data_q;
endmodule

// File: rtl/nanq_unit.sv
module nanq_unit #(
  parameter int unsigned EXP_W  = nanq_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W = nanq_pkg::DEF_FRAC_W,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_quiet_req,
  input  logic         mode_2008,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_is_nan,
  output logic         out_is_snan,
  output logic         out_invalid
);
  import nanq_pkg::*;

  localparam int unsigned FL_W = $bits(nanq_flags_t);
  localparam int unsigned PW   = W + FL_W;

  logic          c_nan;
  logic          c_snan;
  logic [W-1:0]  q_data;
  logic          q_inv;
  nanq_flags_t   flags_in;
  nanq_flags_t   flags_out;
  logic [PW-1:0] pay_in;
  logic [PW-1:0] pay_out;

  nanq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_classify (
    .operand   (in_data),
    .mode_2008 (mode_2008),
    .is_nan    (c_nan),
    .is_snan   (c_snan)
  );

  nanq_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_quieter (
    .operand   (in_data),
    .mode_2008 (mode_2008),
    .quiet_req (in_quiet_req),
    .is_snan   (c_snan),
    .result    (q_data),
    .invalid   (q_inv)
  );

  always_comb begin
    flags_in.is_nan  = c_nan;
    flags_in.is_snan = c_snan;
    flags_in.invalid = q_inv;
  end

  assign pay_in = {q_data, flags_in};

  nanq_stage #(.DW(PW)) i_stage (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (in_valid),
    .s_ready   (in_ready),
    .s_payload (pay_in),
    .m_valid   (out_valid),
    .m_ready   (out_ready),
    .m_payload (pay_out)
  );

  assign out_data    = pay_out[PW-1:FL_W];
  assign flags_out   = nanq_flags_t'(pay_out[FL_W-1:0]);
  assign out_is_nan  = flags_out.is_nan;
  assign out_is_snan = flags_out.is_snan;
  assign out_invalid = flags_out.invalid;
endmodule

// File: rtl/nanq_unit_chk.sv
module nanq_unit_chk #(
  parameter int unsigned EXP_W  = nanq_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W = nanq_pkg::DEF_FRAC_W,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_sign,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_is_nan,
  input logic         out_is_snan,
  input logic         out_invalid
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_invalid)); // R9

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R9

  AST_SNAN_IS_NAN: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_snan |-> out_is_nan); // R3

  AST_INVALID_ON_SNAN: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_invalid |-> out_is_snan); // R7

  AST_QUIET_STAYS_NAN: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_invalid |-> (&out_data[W-2 -: EXP_W]) && (|out_data[FRAC_W-1:0])); // R6

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_data[W-1] == $past(in_sign)); // R5
endmodule

bind nanq_unit nanq_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_sign     (in_data[W-1]),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_is_nan  (out_is_nan),
  .out_is_snan (out_is_snan),
  .out_invalid (out_invalid)
);

// File: tb/test_nanq_unit.sv
module test_nanq_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        in_quiet_req = 1'b0;
  logic        mode_2008 = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_is_nan, out_is_snan, out_invalid;

  typedef struct {
    logic [63:0] data;
    logic        nan;
    logic        snan;
    logic        inv;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  bit   rand_ready = 0;
  logic [7:0] lfsr = 8'hA5;

  always #(CLK_PERIOD/2) clk = ~clk;

  nanq_unit i_nanq_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_quiet_req(in_quiet_req), .mode_2008(mode_2008),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_is_nan(out_is_nan), .out_is_snan(out_is_snan), .out_invalid(out_invalid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [63:0] d, input logic m, input logic req);
    exp_t e;
    logic [51:0] f;
    f      = d[51:0];
    e.nan  = (d[62:52] == 11'h7FF) && (f != 0);
    e.snan = e.nan && (m ^ f[51]);
    e.inv  = req && e.snan;
    e.data = d;
    e.tag  = "R8";
    if (e.inv) begin
      if (m) begin
        f[51] = 1'b1;
        e.tag = "R4";
      end else begin
        f[51] = 1'b0;
        e.tag = "R5";
        if (f == 0) begin
          f[50] = 1'b1;
          e.tag = "R6";
        end
      end
      e.data = {d[63:52], f};
    end
    return e;
  endfunction

  task automatic send(input logic [63:0] d, input logic m, input logic req);
    bit took;
    @(negedge clk);
    in_valid     = 1'b1;
    in_data      = d;
    mode_2008    = m;
    in_quiet_req = req;
    forever begin
      #1 took = in_ready;
      @(posedge clk);
      if (took) break;
      @(negedge clk);
    end
    exp_q.push_back(model(d, m, req));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // out_ready driver, changes just after the rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = rand_ready ? lfsr[0] : 1'b1;
  end

  // monitor and scoreboard; also back-pressure rules (R9)
  logic [63:0] held_data;
  bit          held = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(in_ready == (!out_valid || out_ready), "R9 ready rule", {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
      if (held) begin
        check(out_valid && out_data == held_data, "R9 hold", out_data, held_data);
      end
      held = out_valid && !out_ready;
      held_data = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected output", out_data, 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_data == e.data, e.tag, out_data, e.data);
          check(out_is_nan == e.nan, "R2", {63'd0, out_is_nan}, {63'd0, e.nan});
          check(out_is_snan == e.snan, "R3", {63'd0, out_is_snan}, {63'd0, e.snan});
          check(out_invalid == e.inv, "R7", {63'd0, out_invalid}, {63'd0, e.inv});
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1 out_valid", {63'd0, out_valid}, 64'd0);
    check(in_ready == 1'b1, "R1 in_ready", {63'd0, in_ready}, 64'd1);
    for (int pass = 0; pass < 2; pass++) begin
      rand_ready = (pass == 1);
      for (int m = 0; m < 2; m++) begin
        for (int r = 0; r < 2; r++) begin
          send(64'h7FF8_0000_0000_0001, m[0], r[0]); // bit51 set NaN
          send(64'h7FF0_0000_0000_0001, m[0], r[0]); // bit51 clear NaN
          send(64'h7FF8_0000_0000_0000, m[0], r[0]); // R6 repair case in legacy
          send(64'hFFF8_0000_0000_0000, m[0], r[0]); // R6 with sign
          send(64'hFFF8_0000_0000_0100, m[0], r[0]); // R5 no repair
          send(64'h7FF0_0000_0000_0000, m[0], r[0]); // infinity, R2
          send(64'h0000_0000_0000_0000, m[0], r[0]); // zero
          send(64'h3FF0_0000_0000_0000, m[0], r[0]); // normal
          send(64'hFFF7_FFFF_FFFF_FFFF, m[0], r[0]); // full payload
          send(64'h7FFC_0000_0000_0000, m[0], r[0]); // bits 51,50 set
        end
      end
    end
    // back-to-back stream with stalls
    rand_ready = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      in_valid     = 1'b1;
      in_data      = {i[0], 11'h7FF, i[1], 45'd0, i[7:2]};
      mode_2008    = i[2];
      in_quiet_req = i[3] | i[0];
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
      exp_q.push_back(model(in_data, mode_2008, in_quiet_req));
    end
    @(negedge clk);
    in_valid = 1'b0;
    rand_ready = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R9 drained", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule